// File: doc/BRIEF.md
# Partitioned SIMD Prefix Adder

This block is a combinational 64-bit adder that can be split at run time into packed sub-word lanes. A two-bit mode input picks one of four lane widths: eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes or a single 64-bit lane. Each lane adds its slice of the two operands plus a shared carry-in. No carry ever crosses from one lane into the next.

The datapath is made of identical 8-bit units. Each unit forms the group generate and group propagate of its slice. A Kogge-Stone parallel-prefix network merges these group signals across the units. Before the merge, the propagate of every unit at the bottom of a lane is cleared, so a lane boundary stops carries inside the tree itself. At the same point the carry-in is folded into the generate of that bottom unit. Each node of the tree drives at most two nodes in the level above it.

There is a carry-out for each 8-bit unit. Only the unit at the top of each lane may report a carry-out.

Top module: `spa_simd_adder`

## Requirements
- R1: With mode 2'b00, every byte k of the sum equals (a byte k + b byte k + carry-in) mod 256. Bytes are independent.
- R2: With mode 2'b01, every 16-bit half-word lane k of the sum equals (a lane k + b lane k + carry-in) mod 2^16.
- R3: With mode 2'b10, each of the two 32-bit lanes of the sum equals (a lane + b lane + carry-in) mod 2^32.
- R4: With mode 2'b11, {cout[7], sum} equals the full 65-bit value a + b + carry-in.
- R5: The carry-in enters at the least significant bit of every active lane, and only there.
- R6: No carry crosses a lane boundary. With a all ones, b zero and carry-in 1, every lane sums to zero in every mode.
- R7: cout bit u belongs to 8-bit unit u. For a lane spanning units lo..hi, cout[hi] is the carry out of that lane's top bit. All of cout[lo..hi-1] are zero.
- R8: The outputs depend only on the current inputs. A change of operands or mode is visible without any clock edge.
- R9: When all inputs are known, sum and cout carry no unknown bits. With all inputs zero, both outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 64 | First packed operand |
| b_i | input | 64 | Second packed operand |
| cin_i | input | 1 | Carry-in added at the bottom of every lane |
| mode_i | input | 2 | Lane width: 00=8, 01=16, 10=32, 11=64 bits |
| sum_o | output | 64 | Packed lane sums |
| cout_o | output | 8 | Carry-out per 8-bit unit, valid at lane tops |

## Verification
The bench builds the block with its default parameters: 8-bit units and eight of them. This makes every prefix level and every one of the four lane widths reachable, including the full-width lane where the tree carries across all three levels. A behavioural per-lane model checks random operands in each mode. Table vectors and directed cases cover all-ones operands, which would leak a carry over any lane boundary that is not gated, and patterns where a carry stops exactly at a boundary.

// File: rtl/spa_pkg.sv
package spa_pkg;

    typedef struct packed {
        logic g;
        logic p;
    } spa_gp_t;

    typedef enum logic [1:0] {
        SPA_LANE8  = 2'b00,
        SPA_LANE16 = 2'b01,
        SPA_LANE32 = 2'b10,
        SPA_LANE64 = 2'b11
    } spa_mode_e;

endpackage

// File: rtl/spa_gp_unit.sv
module spa_gp_unit
    import spa_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output spa_gp_t      gp_o,
    output logic [W-1:0] sum_o
);

    logic [W-1:0] p_d;
    logic [W-1:0] g_d;
    logic         run_c;
    logic         grp_g;

    always_comb begin
        p_d   = a_i ^ b_i;
        g_d   = a_i & b_i;
        run_c = cin_i;
        grp_g = 1'b0;
        sum_o = '0;
        for (int k = 0; k < W; k++) begin
            sum_o[k] = p_d[k] ^ run_c;
            run_c    = g_d[k] | (p_d[k] & run_c);
            grp_g    = g_d[k] | (p_d[k] & grp_g);
        end
        gp_o.g = grp_g;
        gp_o.p = &p_d;
    end

endmodule

// File: rtl/spa_lane_mask.sv
module spa_lane_mask #(
    parameter int NUM_UNITS = 8,
    parameter int MODE_W    = 2
) (
    input  logic [MODE_W-1:0]    mode_i,
    output logic [NUM_UNITS-1:0] bottom_o,
    output logic [NUM_UNITS-1:0] top_o
);

    int span_d;

    always_comb begin
        span_d = 32'sd1 <<< mode_i;
        if (span_d > NUM_UNITS) begin
            span_d = NUM_UNITS;
        end
        for (int i = 0; i < NUM_UNITS; i++) begin
            bottom_o[i] = ((i % span_d) == 0);
            top_o[i]    = ((i % span_d) == (span_d - 1));
        end
    end

endmodule

// File: rtl/spa_prefix_net.sv
module spa_prefix_net
    import spa_pkg::*;
#(
    parameter int NUM_UNITS = 8
) (
    input  spa_gp_t [NUM_UNITS-1:0] gp_i,
    input  logic    [NUM_UNITS-1:0] bottom_i,
    input  logic    [NUM_UNITS-1:0] top_i,
    input  logic                    cin_i,
    output logic    [NUM_UNITS-1:0] unit_cin_o,
    output logic    [NUM_UNITS-1:0] cout_o
);

    localparam int LVLS = $clog2(NUM_UNITS);

    logic [NUM_UNITS-1:0] g_lv [0:LVLS];
    logic [NUM_UNITS-1:0] p_lv [0:LVLS];

    genvar i, lv;

    generate
        for (i = 0; i < NUM_UNITS; i++) begin : g_seed
            assign g_lv[0][i] = gp_i[i].g | (gp_i[i].p & cin_i & bottom_i[i]);
            assign p_lv[0][i] = gp_i[i].p & ~bottom_i[i];
        end

        for (lv = 0; lv < LVLS; lv++) begin : g_level
            for (i = 0; i < NUM_UNITS; i++) begin : g_node
                if (i >= (1 << lv)) begin : g_merge
                    assign g_lv[lv+1][i] = g_lv[lv][i] | (p_lv[lv][i] & g_lv[lv][i-(1<<lv)]);
                    assign p_lv[lv+1][i] = p_lv[lv][i] & p_lv[lv][i-(1<<lv)];
                end else begin : g_pass
                    assign g_lv[lv+1][i] = g_lv[lv][i];
                    assign p_lv[lv+1][i] = p_lv[lv][i];
                end
            end
        end

        for (i = 0; i < NUM_UNITS; i++) begin : g_carry
            if (i == 0) begin : g_first
                assign unit_cin_o[i] = cin_i;
            end else begin : g_rest
                assign unit_cin_o[i] = bottom_i[i] ? cin_i : g_lv[LVLS][i-1];
            end
        end
    endgenerate

    assign cout_o = g_lv[LVLS] & top_i;

endmodule

// File: rtl/spa_simd_adder.sv
module spa_simd_adder
    import spa_pkg::*;
#(
    parameter  int UNIT_W    = 8,
    parameter  int NUM_UNITS = 8,
    localparam int DATA_W    = UNIT_W * NUM_UNITS,
    localparam int MODE_W    = $clog2($clog2(NUM_UNITS) + 1)
) (
    input  logic [DATA_W-1:0]    a_i,
    input  logic [DATA_W-1:0]    b_i,
    input  logic                 cin_i,
    input  logic [MODE_W-1:0]    mode_i,
    output logic [DATA_W-1:0]    sum_o,
    output logic [NUM_UNITS-1:0] cout_o
);

    spa_gp_t [NUM_UNITS-1:0] unit_gp;
    logic    [NUM_UNITS-1:0] unit_cin;
    logic    [NUM_UNITS-1:0] lane_bottom;
    logic    [NUM_UNITS-1:0] lane_top;

    spa_lane_mask #(
        .NUM_UNITS (NUM_UNITS),
        .MODE_W    (MODE_W)
    ) u_mask (
        .mode_i   (mode_i),
        .bottom_o (lane_bottom),
        .top_o    (lane_top)
    );

    genvar u;
    generate
        for (u = 0; u < NUM_UNITS; u++) begin : g_unit
            spa_gp_unit #(
                .W (UNIT_W)
            ) u_gp (
                .a_i   (a_i[u*UNIT_W +: UNIT_W]),
                .b_i   (b_i[u*UNIT_W +: UNIT_W]),
                .cin_i (unit_cin[u]),
                .gp_o  (unit_gp[u]),
                .sum_o (sum_o[u*UNIT_W +: UNIT_W])
            );
        end
    endgenerate

    spa_prefix_net #(
        .NUM_UNITS (NUM_UNITS)
    ) u_net (
        .gp_i       (unit_gp),
        .bottom_i   (lane_bottom),
        .top_i      (lane_top),
        .cin_i      (cin_i),
        .unit_cin_o (unit_cin),
        .cout_o     (cout_o)
    );

endmodule

// File: rtl/spa_simd_adder_chk.sv
module spa_simd_adder_chk #(
    parameter  int UNIT_W    = 8,
    parameter  int NUM_UNITS = 8,
    localparam int DATA_W    = UNIT_W * NUM_UNITS,
    localparam int MODE_W    = $clog2($clog2(NUM_UNITS) + 1),
    localparam int FULL_MODE = $clog2(NUM_UNITS)
) (
    input logic [DATA_W-1:0]    a_i,
    input logic [DATA_W-1:0]    b_i,
    input logic                 cin_i,
    input logic [MODE_W-1:0]    mode_i,
    input logic [DATA_W-1:0]    sum_o,
    input logic [NUM_UNITS-1:0] cout_o
);

    logic [DATA_W:0] wide_ref;
    logic [UNIT_W:0] byte_ref;
    int              span;

    always_comb begin
        wide_ref = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, cin_i};
        span     = 32'sd1 <<< mode_i;
        if (!$isunknown({a_i, b_i, cin_i, mode_i})) begin
            AST_OUTPUTS_KNOWN: assert (!$isunknown({sum_o, cout_o}));  // R9
            byte_ref = {1'b0, a_i[UNIT_W-1:0]} + {1'b0, b_i[UNIT_W-1:0]} + {{UNIT_W{1'b0}}, cin_i};
            AST_LOW_UNIT_TAKES_CIN: assert (sum_o[UNIT_W-1:0] == byte_ref[UNIT_W-1:0]);  // R5
            for (int i = 0; i < NUM_UNITS; i++) begin
                if ((span <= NUM_UNITS) && ((i % span) != (span - 1))) begin
                    AST_COUT_ONLY_AT_LANE_TOP: assert (!cout_o[i]);  // R7
                end
            end
            if (int'(mode_i) == FULL_MODE) begin
                AST_FULL_WIDTH_SUM: assert ({cout_o[NUM_UNITS-1], sum_o} == wide_ref);  // R4
            end
            if (mode_i == '0) begin
                for (int i = 0; i < NUM_UNITS; i++) begin
                    AST_BYTE_LANES_INDEPENDENT: assert ({cout_o[i], sum_o[i*UNIT_W +: UNIT_W]} ==
                        ({1'b0, a_i[i*UNIT_W +: UNIT_W]} + {1'b0, b_i[i*UNIT_W +: UNIT_W]}
                         + {{UNIT_W{1'b0}}, cin_i}));  // R1
                end
            end
        end
    end

endmodule

bind spa_simd_adder spa_simd_adder_chk #(
    .UNIT_W    (UNIT_W),
    .NUM_UNITS (NUM_UNITS)
) u_chk (
    .a_i    (a_i),
    .b_i    (b_i),
    .cin_i  (cin_i),
    .mode_i (mode_i),
    .sum_o  (sum_o),
    .cout_o (cout_o)
);

// File: tb/spa_simd_adder_tb.sv
module spa_simd_adder_tb;

    localparam int NV = 9;
    localparam logic [1:0] TMODE [NV] = '{2'd3, 2'd0, 2'd1, 2'd2, 2'd0, 2'd1, 2'd3, 2'd2, 2'd0};
    localparam logic       TCIN  [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
    localparam logic [63:0] TA [NV] = '{
        64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF,
        64'hFFFF_FFFF_FFFF_FFFF, 64'h00FF_00FF_00FF_00FF, 64'h00FF_00FF_00FF_00FF,
        64'h0000_0000_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF, 64'h0102_0304_0506_0708};
    localparam logic [63:0] TB [NV] = '{
        64'h0, 64'h0, 64'h0, 64'h0,
        64'h0001_0001_0001_0001, 64'h0001_0001_0001_0001,
        64'h1, 64'h1, 64'h1010_1010_1010_1010};
    localparam logic [63:0] TSUM [NV] = '{
        64'h0, 64'h0, 64'h0, 64'h0, 64'h0,
        64'h0100_0100_0100_0100, 64'h0000_0001_0000_0000, 64'h0,
        64'h1213_1415_1617_1819};
    localparam logic [7:0] TCOUT [NV] = '{
        8'h80, 8'hFF, 8'hAA, 8'h88, 8'h55, 8'h00, 8'h00, 8'h08, 8'h00};

    string ttag [NV] = '{"R6", "R6", "R6", "R6", "R7", "R2", "R4", "R3", "R5"};

    logic        clk;
    logic        rst;
    logic [63:0] a;
    logic [63:0] b;
    logic        cin;
    logic [1:0]  mode;
    logic [63:0] sum;
    logic [7:0]  cout;

    int n_checks;
    int n_fail;
    int cycles;
    bit done;

    spa_simd_adder u_dut (
        .a_i    (a),
        .b_i    (b),
        .cin_i  (cin),
        .mode_i (mode),
        .sum_o  (sum),
        .cout_o (cout)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 50000 && !done) begin
            done = 1'b1;
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: run did not finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    function automatic void model(input logic [1:0] m, input logic c,
                                  input logic [63:0] x, input logic [63:0] y,
                                  output logic [63:0] es, output logic [7:0] ec);
        int w = 8 << m;
        int units = 1 << m;
        logic [64:0] msk = (65'd1 << w) - 65'd1;
        es = '0;
        ec = '0;
        for (int l = 0; l < (8 >> m); l++) begin
            logic [64:0] xs = ({1'b0, x} >> (l * w)) & msk;
            logic [64:0] ys = ({1'b0, y} >> (l * w)) & msk;
            logic [64:0] s  = xs + ys + {64'd0, c};
            es = es | 64'((s & msk) << (l * w));
            ec[(l + 1) * units - 1] = s[w];
        end
    endfunction

    function automatic string mtag(input logic [1:0] m);
        case (m)
            2'd0:    return "R1";
            2'd1:    return "R2";
            2'd2:    return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] es, input logic [7:0] ec);
        n_checks++;
        if (sum !== es || cout !== ec) begin
            n_fail++;
            $display("FAIL %s: sum=%h cout=%h expected sum=%h cout=%h", tag, sum, cout, es, ec);
        end
    endtask

    task automatic drive(input logic [1:0] m, input logic c, input logic [63:0] x, input logic [63:0] y);
        @(negedge clk);
        mode = m;
        cin  = c;
        a    = x;
        b    = y;
        #1;
    endtask

    initial begin
        logic [63:0] es;
        logic [7:0]  ec;
        n_checks = 0;
        n_fail   = 0;
        cycles   = 0;
        done     = 1'b0;
        rst  = 1'b1;
        a    = '0;
        b    = '0;
        cin  = 1'b0;
        mode = 2'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9", 64'h0, 8'h00);
        rst = 1'b0;

        for (int v = 0; v < NV; v++) begin
            drive(TMODE[v], TCIN[v], TA[v], TB[v]);
            check(ttag[v], TSUM[v], TCOUT[v]);
        end

        for (int m = 0; m < 4; m++) begin
            for (int n = 0; n < 300; n++) begin
                logic [63:0] x = {$urandom, $urandom};
                logic [63:0] y = {$urandom, $urandom};
                if (n % 5 == 0) y = ~x;
                if (n % 7 == 0) x = '1;
                drive(2'(m), 1'($urandom), x, y);
                model(2'(m), cin, a, b, es, ec);
                check(mtag(2'(m)), es, ec);
            end
        end

        // R6: all-ones plus carry-in rolls each lane to zero with cout at lane tops
        for (int m = 0; m < 4; m++) begin
            drive(2'(m), 1'b1, '1, '0);
            model(2'(m), 1'b1, '1, '0, es, ec);
            check("R6", 64'h0, ec);
        end

        // R5: carry-in lands in every lane, nowhere else
        drive(2'd0, 1'b1, '0, '0);
        check("R5", 64'h0101_0101_0101_0101, 8'h00);
        drive(2'd2, 1'b1, '0, '0);
        check("R5", 64'h0000_0001_0000_0001, 8'h00);

        // R7: a lane's lower unit carry stays inside the lane
        drive(2'd1, 1'b0, 64'h0000_0000_0000_00FF, 64'h0000_0000_0000_0001);
        check("R7", 64'h0000_0000_0000_0100, 8'h00);

        // R8: mid-cycle change of mode visible with no clock edge
        drive(2'd3, 1'b0, 64'h0000_0000_FFFF_FFFF, 64'h1);
        check("R8", 64'h0000_0001_0000_0000, 8'h00);
        #0.5 mode = 2'd2;
        #0.5;
        check("R8", 64'h0, 8'h08);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule